// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits between instruction fetch and decode in a small integer core. It takes a 32-bit word from the fetch stage and looks at the two least significant bits. If they are `11`, the word is already a full-length instruction and goes out unchanged. Otherwise the low 16 bits hold a short instruction. The block rewrites it as the 32-bit base-integer instruction that does the same thing, so the decoder only ever sees full-length encodings.

The rewrite rebuilds every field of the long form. It gathers immediate bits that the short form scatters, and sign-extends or scales them as the target instruction needs. It widens 3-bit register fields to x8..x15. It also supplies the registers that the short form leaves implicit: the stack pointer x2, the link register x1 and the zero register x0. Short forms that this 32-bit integer core cannot execute raise an illegal flag instead of producing an expansion. These are the floating-point loads and stores, the 64-bit-only arithmetic, and the reserved or zero-immediate encodings. The block is purely combinational. Fetch alignment and program-counter stepping are handled elsewhere.

Top module: `short_insn_expander`

## Requirements
- R1: When fetchWord[1:0] is 2'b11, expandedWord equals fetchWord, wasCompressed is 0 and isIllegal is 0.
- R2: When fetchWord[1:0] is not 2'b11, wasCompressed is 1, fetchWord[31:16] has no effect, and every legal expansion has bits [1:0] equal to 2'b11.
- R3: A 3-bit register field n in a short form selects register x(8+n) in the expansion.
- R4: The short add-immediate forms expand to ADDI (opcode 0010011, funct3 000) with a sign-extended 6-bit immediate. The add-immediate uses rd as both destination and source. Load-immediate uses x0 as the source. The stack forms are ADDI rd',x2,zero-extended imm*4 and ADDI x2,x2,sign-extended imm*16. The load-upper form expands to LUI (0110111) with a sign-extended 6-bit upper immediate.
- R5: The word load and store forms expand to LW (0000011, funct3 010) and SW (0100011, funct3 010) with zero-extended byte offsets that are multiples of 4. The stack-relative forms use x2 as the base.
- R6: The move form expands to ADD rd,x0,rs2 and the add form expands to ADD rd,rd,rs2 (opcode 0110011, funct3 000, funct7 0).
- R7: The register-pair forms SUB, XOR, OR and AND expand with funct3 000/100/110/111, and SUB uses funct7 0100000. The immediate forms expand to ANDI (funct3 111), SRLI (funct3 101), SRAI (funct3 101, imm[11:5]=0100000) and SLLI (funct3 001).
- R8: The short jump expands to JAL x0 and the short call expands to JAL x1 (opcode 1101111), each with a sign-extended 12-bit offset.
- R9: The register-jump form expands to JALR x0,0(rs1) and the register-call form expands to JALR x1,0(rs1) (opcode 1100111).
- R10: Branch-if-zero expands to BEQ rs1',x0 and branch-if-nonzero expands to BNE rs1',x0 (opcode 1100011), each with a sign-extended 9-bit offset.
- R11: isIllegal is 1 for each of the following:
  - the all-zero half-word;
  - a zero immediate in the stack-adjust, stack-address or load-upper forms;
  - a stack word load into x0;
  - a register jump through x0;
  - a shift amount with bit 5 set;
  - the 64-bit-only register-pair forms;
  - all floating-point load and store forms;
  - quadrant 0 funct3 100.

  An illegal input gives expandedWord = {16'h0, fetchWord[15:0]}.
- R12: The half-word 16'h9002 expands to the breakpoint instruction 32'h00100073.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetchWord | input | 32 | Word delivered by fetch |
| expandedWord | output | 32 | Full-length instruction, or pass-through |
| wasCompressed | output | 1 | Input low bits were not 2'b11 |
| isIllegal | output | 1 | Short form has no legal expansion here |

## Verification
Each short form is applied with register numbers and immediates chosen so that every scattered immediate bit lands in a distinct place. Negative and positive offsets are both used, which separates a wrong bit permutation from a sign-extension fault. The pass-through case and short inputs with a non-zero upper half show whether the two halves of the fetch word are kept apart. The reserved and unsupported encodings are applied one by one, each differing from a legal form by a single field, so a missing illegal condition surfaces directly. The breakpoint and no-operation encodings check the two fixed expansions.

// File: rtl/sie_pkg.sv
package sie_pkg;

  localparam int InstrW = 32;
  localparam int HalfW  = 16;
  localparam int RegW   = 5;

  localparam logic [6:0] OpImm    = 7'b0010011;
  localparam logic [6:0] OpReg    = 7'b0110011;
  localparam logic [6:0] OpLoad   = 7'b0000011;
  localparam logic [6:0] OpStore  = 7'b0100011;
  localparam logic [6:0] OpLui    = 7'b0110111;
  localparam logic [6:0] OpJal    = 7'b1101111;
  localparam logic [6:0] OpJalr   = 7'b1100111;
  localparam logic [6:0] OpBranch = 7'b1100011;
  localparam logic [6:0] OpSystem = 7'b1110011;

  typedef enum logic [2:0] {
    FMT_R, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
  } fmtE;

  typedef enum logic [2:0] {
    REG_ZERO, REG_SP, REG_RA, REG_FULL_HI, REG_FULL_LO, REG_PRIME_HI, REG_PRIME_LO
  } regSelE;

  typedef enum logic [3:0] {
    IMM_ZERO, IMM_ONE, IMM_SPN, IMM_WORD, IMM_CI, IMM_JUMP, IMM_SP16,
    IMM_UPPER, IMM_SHAMT, IMM_BRANCH, IMM_LDSP, IMM_STSP
  } immSelE;

  typedef struct packed {
    fmtE        fmt;
    logic [6:0] opcode;
    logic [2:0] funct3;
    logic [6:0] funct7;
    regSelE     rdSel;
    regSelE     rs1Sel;
    regSelE     rs2Sel;
    immSelE     immSel;
    logic       compressed;
    logic       illegal;
  } strobeT;

endpackage

// File: rtl/sie_ctrl.sv
module sie_ctrl
  import sie_pkg::*;
(
  input  logic [InstrW-1:0] fetchWord,
  output strobeT            strobes
);

  logic [HalfW-1:0] cw;
  logic [2:0]       f3;
  logic [1:0]       quad;
  logic             hiZero;
  logic             loZero;
  logic             ci6Zero;

  assign cw      = fetchWord[HalfW-1:0];
  assign f3      = cw[15:13];
  assign quad    = cw[1:0];
  assign hiZero  = (cw[11:7] == 5'd0);
  assign loZero  = (cw[6:2] == 5'd0);
  assign ci6Zero = (cw[12] == 1'b0) && loZero;

  always_comb begin
    strobes            = '0;
    strobes.fmt        = FMT_I;
    strobes.opcode     = OpImm;
    strobes.rdSel      = REG_ZERO;
    strobes.rs1Sel     = REG_ZERO;
    strobes.rs2Sel     = REG_ZERO;
    strobes.immSel     = IMM_ZERO;
    strobes.compressed = (quad != 2'b11);
    strobes.illegal    = 1'b0;

    unique case (quad)
      2'b00: begin
        unique case (f3)
          3'b000: begin
            strobes.rdSel   = REG_PRIME_LO;
            strobes.rs1Sel  = REG_SP;
            strobes.immSel  = IMM_SPN;
            strobes.illegal = (cw[12:5] == 8'd0);
          end
          3'b010: begin
            strobes.opcode = OpLoad;
            strobes.funct3 = 3'b010;
            strobes.rdSel  = REG_PRIME_LO;
            strobes.rs1Sel = REG_PRIME_HI;
            strobes.immSel = IMM_WORD;
          end
          3'b110: begin
            strobes.fmt    = FMT_S;
            strobes.opcode = OpStore;
            strobes.funct3 = 3'b010;
            strobes.rs1Sel = REG_PRIME_HI;
            strobes.rs2Sel = REG_PRIME_LO;
            strobes.immSel = IMM_WORD;
          end
          default: strobes.illegal = 1'b1;
        endcase
      end

      2'b01: begin
        unique case (f3)
          3'b000: begin
            strobes.rdSel  = REG_FULL_HI;
            strobes.rs1Sel = REG_FULL_HI;
            strobes.immSel = IMM_CI;
          end
          3'b001: begin
            strobes.fmt    = FMT_J;
            strobes.opcode = OpJal;
            strobes.rdSel  = REG_RA;
            strobes.immSel = IMM_JUMP;
          end
          3'b010: begin
            strobes.rdSel  = REG_FULL_HI;
            strobes.immSel = IMM_CI;
          end
          3'b011: begin
            if (cw[11:7] == 5'd2) begin
              strobes.rdSel  = REG_SP;
              strobes.rs1Sel = REG_SP;
              strobes.immSel = IMM_SP16;
            end else begin
              strobes.fmt    = FMT_U;
              strobes.opcode = OpLui;
              strobes.rdSel  = REG_FULL_HI;
              strobes.immSel = IMM_UPPER;
            end
            strobes.illegal = ci6Zero;
          end
          3'b100: begin
            strobes.rdSel  = REG_PRIME_HI;
            strobes.rs1Sel = REG_PRIME_HI;
            unique case (cw[11:10])
              2'b00: begin
                strobes.funct3  = 3'b101;
                strobes.immSel  = IMM_SHAMT;
                strobes.illegal = cw[12];
              end
              2'b01: begin
                strobes.funct3  = 3'b101;
                strobes.funct7  = 7'b0100000;
                strobes.immSel  = IMM_SHAMT;
                strobes.illegal = cw[12];
              end
              2'b10: begin
                strobes.funct3 = 3'b111;
                strobes.immSel = IMM_CI;
              end
              default: begin
                strobes.fmt     = FMT_R;
                strobes.opcode  = OpReg;
                strobes.rs2Sel  = REG_PRIME_LO;
                strobes.illegal = cw[12];
                unique case (cw[6:5])
                  2'b00: begin
                    strobes.funct3 = 3'b000;
                    strobes.funct7 = 7'b0100000;
                  end
                  2'b01:   strobes.funct3 = 3'b100;
                  2'b10:   strobes.funct3 = 3'b110;
                  default: strobes.funct3 = 3'b111;
                endcase
              end
            endcase
          end
          3'b101: begin
            strobes.fmt    = FMT_J;
            strobes.opcode = OpJal;
            strobes.immSel = IMM_JUMP;
          end
          default: begin
            strobes.fmt    = FMT_B;
            strobes.opcode = OpBranch;
            strobes.funct3 = {2'b00, cw[13]};
            strobes.rs1Sel = REG_PRIME_HI;
            strobes.immSel = IMM_BRANCH;
          end
        endcase
      end

      2'b10: begin
        unique case (f3)
          3'b000: begin
            strobes.funct3  = 3'b001;
            strobes.rdSel   = REG_FULL_HI;
            strobes.rs1Sel  = REG_FULL_HI;
            strobes.immSel  = IMM_SHAMT;
            strobes.illegal = cw[12];
          end
          3'b010: begin
            strobes.opcode  = OpLoad;
            strobes.funct3  = 3'b010;
            strobes.rdSel   = REG_FULL_HI;
            strobes.rs1Sel  = REG_SP;
            strobes.immSel  = IMM_LDSP;
            strobes.illegal = hiZero;
          end
          3'b100: begin
            if (loZero) begin
              if (cw[12] && hiZero) begin
                strobes.opcode = OpSystem;
                strobes.immSel = IMM_ONE;
              end else begin
                strobes.opcode  = OpJalr;
                strobes.rdSel   = cw[12] ? REG_RA : REG_ZERO;
                strobes.rs1Sel  = REG_FULL_HI;
                strobes.illegal = hiZero;
              end
            end else begin
              strobes.fmt    = FMT_R;
              strobes.opcode = OpReg;
              strobes.rdSel  = REG_FULL_HI;
              strobes.rs1Sel = cw[12] ? REG_FULL_HI : REG_ZERO;
              strobes.rs2Sel = REG_FULL_LO;
            end
          end
          3'b110: begin
            strobes.fmt    = FMT_S;
            strobes.opcode = OpStore;
            strobes.funct3 = 3'b010;
            strobes.rs1Sel = REG_SP;
            strobes.rs2Sel = REG_FULL_LO;
            strobes.immSel = IMM_STSP;
          end
          default: strobes.illegal = 1'b1;
        endcase
      end

      default: strobes.illegal = 1'b0;
    endcase
  end

  // R11
  always_comb begin
    zero_half_chk: assert (!(strobes.compressed && cw == 16'h0000) || strobes.illegal);
  end

endmodule

// File: rtl/sie_datapath.sv
module sie_datapath
  import sie_pkg::*;
(
  input  logic [InstrW-1:0] fetchWord,
  input  strobeT            strobes,
  output logic [InstrW-1:0] expandedWord
);

  logic [HalfW-1:0]  cw;
  logic [RegW-1:0]   rdNum;
  logic [RegW-1:0]   rs1Num;
  logic [RegW-1:0]   rs2Num;
  logic [InstrW-1:0] immVal;
  logic [InstrW-1:0] assembled;

  assign cw = fetchWord[HalfW-1:0];

  function automatic logic [RegW-1:0] pickReg(input regSelE sel, input logic [HalfW-1:0] w);
    logic [RegW-1:0] r;
    unique case (sel)
      REG_SP:       r = 5'd2;
      REG_RA:       r = 5'd1;
      REG_FULL_HI:  r = w[11:7];
      REG_FULL_LO:  r = w[6:2];
      REG_PRIME_HI: r = {2'b01, w[9:7]};
      REG_PRIME_LO: r = {2'b01, w[4:2]};
      default:      r = 5'd0;
    endcase
    return r;
  endfunction

  assign rdNum  = pickReg(strobes.rdSel, cw);
  assign rs1Num = pickReg(strobes.rs1Sel, cw);
  assign rs2Num = pickReg(strobes.rs2Sel, cw);

  always_comb begin
    unique case (strobes.immSel)
      IMM_ONE:    immVal = 32'd1;
      IMM_SPN:    immVal = {22'd0, cw[10:7], cw[12:11], cw[5], cw[6], 2'b00};
      IMM_WORD:   immVal = {25'd0, cw[5], cw[12:10], cw[6], 2'b00};
      IMM_CI:     immVal = {{26{cw[12]}}, cw[12], cw[6:2]};
      IMM_JUMP:   immVal = {{20{cw[12]}}, cw[12], cw[8], cw[10:9], cw[6], cw[7],
                            cw[2], cw[11], cw[5:3], 1'b0};
      IMM_SP16:   immVal = {{22{cw[12]}}, cw[12], cw[4:3], cw[5], cw[2], cw[6], 4'b0000};
      IMM_UPPER:  immVal = {{14{cw[12]}}, cw[12], cw[6:2], 12'd0};
      IMM_SHAMT:  immVal = {20'd0, strobes.funct7, cw[6:2]};
      IMM_BRANCH: immVal = {{23{cw[12]}}, cw[12], cw[6:5], cw[2], cw[11:10], cw[4:3], 1'b0};
      IMM_LDSP:   immVal = {24'd0, cw[3:2], cw[12], cw[6:4], 2'b00};
      IMM_STSP:   immVal = {24'd0, cw[8:7], cw[12:9], 2'b00};
      default:    immVal = 32'd0;
    endcase
  end

  always_comb begin
    unique case (strobes.fmt)
      FMT_R: assembled = {strobes.funct7, rs2Num, rs1Num, strobes.funct3, rdNum, strobes.opcode};
      FMT_S: assembled = {immVal[11:5], rs2Num, rs1Num, strobes.funct3, immVal[4:0], strobes.opcode};
      FMT_B: assembled = {immVal[12], immVal[10:5], rs2Num, rs1Num, strobes.funct3,
                          immVal[4:1], immVal[11], strobes.opcode};
      FMT_U: assembled = {immVal[31:12], rdNum, strobes.opcode};
      FMT_J: assembled = {immVal[20], immVal[10:1], immVal[11], immVal[19:12], rdNum, strobes.opcode};
      default: assembled = {immVal[11:0], rs1Num, strobes.funct3, rdNum, strobes.opcode};
    endcase
  end

  always_comb begin
    if (!strobes.compressed)   expandedWord = fetchWord;
    else if (strobes.illegal)  expandedWord = {16'd0, cw};
    else                       expandedWord = assembled;
  end

  // R3
  always_comb begin
    prime_reg_chk: assert (!(strobes.compressed && !strobes.illegal &&
                             strobes.rs1Sel == REG_PRIME_HI) || expandedWord[19:18] == 2'b01);
  end

  // R5
  always_comb begin
    word_align_chk: assert (!(strobes.compressed && !strobes.illegal) ||
                            (expandedWord[6:0] != OpLoad  || expandedWord[21:20] == 2'b00) &&
                            (expandedWord[6:0] != OpStore || expandedWord[8:7] == 2'b00));
  end

  // R8
  always_comb begin
    link_reg_chk: assert (!(strobes.compressed && !strobes.illegal && expandedWord[6:0] == OpJal) ||
                          expandedWord[11:8] == 4'd0);
  end

endmodule

// File: rtl/short_insn_expander.sv
module short_insn_expander
  import sie_pkg::*;
(
  input  logic [31:0] fetchWord,
  output logic [31:0] expandedWord,
  output logic        wasCompressed,
  output logic        isIllegal
);

  strobeT strobes;

  sie_ctrl i_ctrl (
    .fetchWord (fetchWord),
    .strobes   (strobes)
  );

  sie_datapath i_datapath (
    .fetchWord    (fetchWord),
    .strobes      (strobes),
    .expandedWord (expandedWord)
  );

  assign wasCompressed = strobes.compressed;
  assign isIllegal     = strobes.illegal;

  // R1
  always_comb begin
    passthru_chk: assert (!(fetchWord[1:0] == 2'b11) ||
                          (expandedWord == fetchWord && !isIllegal && !wasCompressed));
  end

  // R2
  always_comb begin
    legal_len_chk: assert (!(wasCompressed && !isIllegal) || expandedWord[1:0] == 2'b11);
  end

  // R11
  always_comb begin
    illegal_out_chk: assert (!isIllegal || expandedWord == {16'd0, fetchWord[15:0]});
  end

endmodule

// File: tb/test_short_insn_expander.sv
module test_short_insn_expander;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchWord = 32'd0;
  logic [31:0] expandedWord;
  logic        wasCompressed;
  logic        isIllegal;
  int          vectors = 0;
  int          miscompares = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  short_insn_expander i_short_insn_expander (
    .fetchWord     (fetchWord),
    .expandedWord  (expandedWord),
    .wasCompressed (wasCompressed),
    .isIllegal     (isIllegal)
  );

  function automatic logic [31:0] encR(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] encI(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                       logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] encS(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3, logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction
  function automatic logic [31:0] encB(logic [12:0] imm, logic [4:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] encJ(logic [20:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [15:0] bCI(logic [2:0] f3, logic [4:0] r, logic [5:0] imm, logic [1:0] q);
    return {f3, imm[5], r, imm[4:0], q};
  endfunction
  function automatic logic [15:0] bSpn(logic [9:0] u, logic [2:0] rdp);
    return {3'b000, u[5:4], u[9:6], u[2], u[3], rdp, 2'b00};
  endfunction
  function automatic logic [15:0] bWord(logic [2:0] f3, logic [6:0] u, logic [2:0] rs1p, logic [2:0] rp);
    return {f3, u[5:3], rs1p, u[2], u[6], rp, 2'b00};
  endfunction
  function automatic logic [15:0] bSp16(logic [9:0] n);
    return {3'b011, n[9], 5'd2, n[4], n[6], n[8:7], n[5], 2'b01};
  endfunction
  function automatic logic [15:0] bLdsp(logic [4:0] rd, logic [7:0] u);
    return {3'b010, u[5], rd, u[4:2], u[7:6], 2'b10};
  endfunction
  function automatic logic [15:0] bStsp(logic [4:0] rs2, logic [7:0] u);
    return {3'b110, u[5:2], u[7:6], rs2, 2'b10};
  endfunction
  function automatic logic [15:0] bCR(logic b12, logic [4:0] r1, logic [4:0] r2);
    return {3'b100, b12, r1, r2, 2'b10};
  endfunction
  function automatic logic [15:0] bPair(logic [1:0] sel, logic [2:0] rdp, logic [2:0] rs2p);
    return {3'b100, 1'b0, 2'b11, rdp, sel, rs2p, 2'b01};
  endfunction
  function automatic logic [15:0] bImmOp(logic [1:0] kind, logic [5:0] imm, logic [2:0] rdp);
    return {3'b100, imm[5], kind, rdp, imm[4:0], 2'b01};
  endfunction
  function automatic logic [15:0] bJmp(logic [2:0] f3, logic [11:0] o);
    return {f3, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] bBr(logic [2:0] f3, logic [2:0] rs1p, logic [8:0] o);
    return {f3, o[8], o[4:3], rs1p, o[7:6], o[2:1], o[5], 2'b01};
  endfunction

  task automatic check(string tag, logic [31:0] w, logic [31:0] expW, logic expC, logic expI);
    @(posedge clk);
    fetchWord = w;
    @(negedge clk);
    vectors++;
    if (expandedWord !== expW || wasCompressed !== expC || isIllegal !== expI) begin
      miscompares++;
      $display("FAIL %s: in=%h actual=%h/c%b/i%b expected=%h/c%b/i%b",
               tag, w, expandedWord, wasCompressed, isIllegal, expW, expC, expI);
    end
  endtask

  task automatic shortOk(string tag, logic [15:0] hw, logic [31:0] expW);
    check(tag, {16'h0000, hw}, expW, 1'b1, 1'b0);
    check(tag, {16'hBEEF, hw}, expW, 1'b1, 1'b0);
  endtask

  task automatic shortBad(string tag, logic [15:0] hw);
    check(tag, {16'hA5C3, hw}, {16'h0000, hw}, 1'b1, 1'b1);
  endtask

  task automatic testReset;
    check("R11 zero word after reset", 32'h0, 32'h0, 1'b1, 1'b1);
  endtask

  task automatic testPassThru;
    check("R1 pass addi", 32'h00A50513, 32'h00A50513, 1'b0, 1'b0);
    check("R1 pass all ones", 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0);
    check("R1 pass lw-like", 32'h1234_5683, 32'h1234_5683, 1'b0, 1'b0);
  endtask

  task automatic testAddImm;
    shortOk("R4 addi", bCI(3'b000, 5'd10, 6'b111101, 2'b01), encI(12'hFFD, 5'd10, 3'b000, 5'd10, 7'h13));
    shortOk("R2 nop", 16'h0001, 32'h00000013);
    shortOk("R4 li", bCI(3'b010, 5'd5, 6'b010001, 2'b01), encI(12'd17, 5'd0, 3'b000, 5'd5, 7'h13));
    shortOk("R4 R3 addi4spn", bSpn(10'h104, 3'd1), encI(12'h104, 5'd2, 3'b000, 5'd9, 7'h13));
    shortOk("R4 addi16sp", bSp16(10'h3C0), encI(12'hFC0, 5'd2, 3'b000, 5'd2, 7'h13));
    shortOk("R4 lui", bCI(3'b011, 5'd7, 6'b100001, 2'b01), {20'hFFFE1, 5'd7, 7'b0110111});
  endtask

  task automatic testLoadStore;
    shortOk("R5 R3 lw", bWord(3'b010, 7'd124, 3'd7, 3'd4), encI(12'd124, 5'd15, 3'b010, 5'd12, 7'h03));
    shortOk("R5 R3 sw", bWord(3'b110, 7'd64, 3'd3, 3'd0), encS(12'd64, 5'd8, 5'd11, 3'b010, 7'h23));
    shortOk("R5 lwsp", bLdsp(5'd20, 8'd252), encI(12'd252, 5'd2, 3'b010, 5'd20, 7'h03));
    shortOk("R5 swsp", bStsp(5'd31, 8'd188), encS(12'd188, 5'd31, 5'd2, 3'b010, 7'h23));
  endtask

  task automatic testRegMove;
    shortOk("R6 mv", bCR(1'b0, 5'd3, 5'd4), encR(7'd0, 5'd4, 5'd0, 3'b000, 5'd3, 7'h33));
    shortOk("R6 add", bCR(1'b1, 5'd3, 5'd4), encR(7'd0, 5'd4, 5'd3, 3'b000, 5'd3, 7'h33));
  endtask

  task automatic testAlu;
    shortOk("R7 sub", bPair(2'b00, 3'd1, 3'd2), encR(7'h20, 5'd10, 5'd9, 3'b000, 5'd9, 7'h33));
    shortOk("R7 xor", bPair(2'b01, 3'd3, 3'd4), encR(7'h00, 5'd12, 5'd11, 3'b100, 5'd11, 7'h33));
    shortOk("R7 or",  bPair(2'b10, 3'd5, 3'd6), encR(7'h00, 5'd14, 5'd13, 3'b110, 5'd13, 7'h33));
    shortOk("R7 and", bPair(2'b11, 3'd7, 3'd0), encR(7'h00, 5'd8, 5'd15, 3'b111, 5'd15, 7'h33));
    shortOk("R7 andi", bImmOp(2'b10, 6'b111000, 3'd5), encI(12'hFF8, 5'd13, 3'b111, 5'd13, 7'h13));
    shortOk("R7 srli", bImmOp(2'b00, 6'd7, 3'd0), encI(12'd7, 5'd8, 3'b101, 5'd8, 7'h13));
    shortOk("R7 srai", bImmOp(2'b01, 6'd31, 3'd6), encI(12'h41F, 5'd14, 3'b101, 5'd14, 7'h13));
    shortOk("R7 slli", bCI(3'b000, 5'd1, 6'd12, 2'b10), encI(12'd12, 5'd1, 3'b001, 5'd1, 7'h13));
  endtask

  task automatic testJumps;
    shortOk("R8 j fwd", bJmp(3'b101, 12'h57A), encJ(21'h00057A, 5'd0));
    shortOk("R8 j back", bJmp(3'b101, 12'hFFE), encJ(21'h1FFFFE, 5'd0));
    shortOk("R8 jal", bJmp(3'b001, 12'h802), encJ(21'h1FF802, 5'd1));
    shortOk("R9 jr", bCR(1'b0, 5'd5, 5'd0), encI(12'd0, 5'd5, 3'b000, 5'd0, 7'h67));
    shortOk("R9 jalr", bCR(1'b1, 5'd6, 5'd0), encI(12'd0, 5'd6, 3'b000, 5'd1, 7'h67));
  endtask

  task automatic testBranches;
    shortOk("R10 beqz back", bBr(3'b110, 3'd2, 9'h100), encB(13'h1F00, 5'd10, 3'b000));
    shortOk("R10 bnez fwd", bBr(3'b111, 3'd6, 9'h0F6), encB(13'h00F6, 5'd14, 3'b001));
  endtask

  task automatic testBreak;
    shortOk("R12 ebreak", 16'h9002, 32'h00100073);
  endtask

  task automatic testIllegal;
    shortBad("R11 zero half", 16'h0000);
    shortBad("R11 addi4spn zero imm", 16'h000C);
    shortBad("R11 addi16sp zero imm", 16'h6101);
    shortBad("R11 lui zero imm", 16'h6281);
    shortBad("R11 lwsp x0", 16'h4002);
    shortBad("R11 jr x0", 16'h8002);
    shortBad("R11 slli shamt5", 16'h1086);
    shortBad("R11 srli shamt5", 16'h9001);
    shortBad("R11 q0 reserved", 16'h8000);
    shortBad("R11 fp load dbl", 16'h2000);
    shortBad("R11 fp load sgl", 16'h6000);
    shortBad("R11 fp store sgl", 16'hE000);
    shortBad("R11 fp ldsp dbl", 16'h2002);
    shortBad("R11 fp stsp dbl", 16'hA002);
    shortBad("R11 subw 64-bit", 16'h9C01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testReset();
    testPassThru();
    testAddImm();
    testLoadStore();
    testRegMove();
    testAlu();
    testJumps();
    testBranches();
    testBreak();
    testIllegal();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule